// File: doc/BRIEF.md
# Signed Integer/Fractional Multiply-Accumulator

This block multiplies two 16-bit two's complement operands and either adds the product into a 40-bit two's complement accumulator or loads the product into it. Software-style register writes load the two operands and a mode bit. The mode bit selects integer arithmetic or Q1.15 fractional arithmetic. In Q1.15 the operand sign bit weighs -1. The 32-bit product is shifted left by one position so that the accumulator's binary point falls between bits 31 and 30.

The accumulator is read one byte at a time through a select input. Four bytes cover bits 31..0, and a fifth byte holds the guard bits 39..32. The block flags a negative accumulator, an all-zero accumulator and a sticky signed overflow. It also produces a rounded 16-bit word. That word carries no sign of its own, so the negative flag supplies it.

Top module: `mac_unit`

## Requirements
- R1: A write with `wr_sel_i`=0 loads operand A from `wr_data_i`, `wr_sel_i`=1 loads operand B, and `wr_sel_i`=2 loads the fractional-mode bit from `wr_data_i[0]`. Reset clears A, B, the mode bit, the accumulator and all flags.
- R2: In integer mode (mode bit 0), a start with `op_mul_i`=0 adds the signed product A*B, sign-extended to 40 bits, into the accumulator. The new value is visible right after the clock edge that samples the start.
- R3: In fractional mode (mode bit 1), the signed 32-bit product is sign-extended to 40 bits and shifted left by one before it is used.
- R4: A start with `op_mul_i`=1 loads the accumulator with the aligned product in place of the sum and leaves the overflow flag unchanged.
- R5: The overflow flag sets when an accumulate adds two values of equal sign and gets a result of the other sign. Once set, it stays set until a clear.
- R6: `clear_i` zeroes the accumulator and the overflow flag on the next edge, and it wins over a simultaneous start.
- R7: `neg_o` equals accumulator bit 39. `zero_o` is 1 exactly when all 40 accumulator bits are 0.
- R8: `rnd_o` is accumulator bits 31..16 plus bit 15, modulo 2^16, in fractional mode, and accumulator bits 15..0 in integer mode.
- R9: `rd_byte_o` shows accumulator bits 8k+7..8k for `rd_sel_i`=k, with k from 0 to 4. Bits 39..32 are at k=4, and selects 5 to 7 read 0.
- R10: Without start or clear, the accumulator holds its value, including across operand and mode writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 A, 1 B, 2 mode |
| wr_data_i | input | 16 | Write data |
| start_i | input | 1 | Start one operation on the held operands |
| op_mul_i | input | 1 | 1 multiply-only, 0 accumulate |
| clear_i | input | 1 | Zero accumulator and flags |
| rd_sel_i | input | 3 | Accumulator byte select |
| rd_byte_o | output | 8 | Selected accumulator byte |
| rnd_o | output | 16 | Rounded result word |
| neg_o | output | 1 | Accumulator sign |
| zero_o | output | 1 | Accumulator is zero |
| ovf_o | output | 1 | Sticky signed overflow |

## Verification
Operand and mode writes take effect at the edge that samples them. An operation started at the following edge uses the written values. The accumulator, the overflow flag and the values derived from them (`neg_o`, `zero_o`, `rnd_o`) change at the single edge that samples start or clear, so each check reads them at the falling edge after that edge. The byte read path is combinational, so all five bytes are stepped through with the controls idle and compared against a bench model of the accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    WSEL_A    = 2'd0,
    WSEL_B    = 2'd1,
    WSEL_MODE = 2'd2
  } wsel_e;
endpackage

// File: rtl/mac_operand_regs.sv
module mac_operand_regs
  import mac_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [OP_W-1:0] wr_data_i,
  output logic [OP_W-1:0] a_o,
  output logic [OP_W-1:0] b_o,
  output logic            frac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o    <= '0;
      b_o    <= '0;
      frac_o <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wsel_e'(wr_sel_i))
        WSEL_A:    a_o    <= wr_data_i;
        WSEL_B:    b_o    <= wr_data_i;
        WSEL_MODE: frac_o <= wr_data_i[0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/mac_product.sv
module mac_product #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             frac_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] raw;
  logic        [ACC_W-1:0]  ext;

  always_comb begin
    raw    = $signed(a_i) * $signed(b_i);
    ext    = {{EXT_W{raw[PROD_W-1]}}, raw};
    // Q1.15 x Q1.15 gives Q2.30; shift to put the point below bit 31
    prod_o = frac_i ? {ext[ACC_W-2:0], 1'b0} : ext;
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_mul_i,
  input  logic             clear_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] sum;
  logic             add_ovf;

  always_comb begin
    sum     = acc_o + prod_i;
    add_ovf = (acc_o[MSB] == prod_i[MSB]) && (sum[MSB] != acc_o[MSB]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (clear_i) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (start_i) begin
      if (op_mul_i) begin
        acc_o <= prod_i;
      end else begin
        acc_o <= sum;
        ovf_o <= ovf_o | add_ovf;
      end
    end
  end
endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             frac_i,
  output logic [OP_W-1:0]  rnd_o
);
  localparam int HI = 2 * OP_W - 1;

  logic [OP_W-1:0] frac_word;

  always_comb begin
    frac_word = acc_i[HI -: OP_W] + OP_W'(acc_i[OP_W-1]);
    rnd_o     = frac_i ? frac_word : acc_i[OP_W-1:0];
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [1:0]                    wr_sel_i,
  input  logic [OP_W-1:0]               wr_data_i,
  input  logic                          start_i,
  input  logic                          op_mul_i,
  input  logic                          clear_i,
  input  logic [$clog2(ACC_W/8+1)-1:0]  rd_sel_i,
  output logic [7:0]                    rd_byte_o,
  output logic [OP_W-1:0]               rnd_o,
  output logic                          neg_o,
  output logic                          zero_o,
  output logic                          ovf_o
);
  localparam int NBYTES = ACC_W / 8;
  localparam int SEL_W  = $clog2(NBYTES + 1);

  logic [OP_W-1:0]  a_q, b_q;
  logic             frac_q;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] acc_q;
  logic [7:0]       bytes [NBYTES];

  mac_operand_regs #(.OP_W(OP_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .a_o(a_q), .b_o(b_q), .frac_o(frac_q)
  );

  mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
    .a_i(a_q), .b_i(b_q), .frac_i(frac_q), .prod_o(prod)
  );

  mac_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .start_i, .op_mul_i, .clear_i,
    .prod_i(prod), .acc_o(acc_q), .ovf_o(ovf_o)
  );

  mac_round #(.OP_W(OP_W), .ACC_W(ACC_W)) u_rnd (
    .acc_i(acc_q), .frac_i(frac_q), .rnd_o(rnd_o)
  );

  for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
    assign bytes[k] = acc_q[8*k +: 8];
  end

  always_comb begin
    rd_byte_o = 8'h00;
    for (int k = 0; k < NBYTES; k++) begin
      if (rd_sel_i == SEL_W'(k)) rd_byte_o = bytes[k];
    end
  end

  assign neg_o  = acc_q[ACC_W-1];
  assign zero_o = ~|acc_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             op_mul_i,
  input logic             clear_i,
  input logic             ovf_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic [ACC_W-1:0] acc_i
);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (zero_o && !ovf_o && !neg_o));

  assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clear_i) |=> ovf_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !clear_i) |=> $stable(acc_i));

  assert_mul_keeps_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_mul_i && !clear_i) |=> (ovf_o == $past(ovf_o)));

  assert_ovf_only_on_acc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(start_i) && !$past(op_mul_i)));
endmodule

bind mac_unit mac_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_mul_i(op_mul_i),
  .clear_i(clear_i), .ovf_o(ovf_o), .zero_o(zero_o), .neg_o(neg_o),
  .acc_i(acc_q)
);

// File: tb/mac_unit_test.sv
`timescale 1ns/1ps
module mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic        op_mul = 1'b0;
  logic        clear = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_byte;
  logic [15:0] rnd;
  logic        neg, zero, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [39:0] m_acc = '0;
  logic [15:0] m_a = '0, m_b = '0;
  bit          m_frac = 1'b0, m_ovf = 1'b0;

  always #4 clk = ~clk;

  mac_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .start_i(start), .op_mul_i(op_mul), .clear_i(clear),
    .rd_sel_i(rd_sel), .rd_byte_o(rd_byte), .rnd_o(rnd), .neg_o(neg),
    .zero_o(zero), .ovf_o(ovf)
  );

  function automatic logic [39:0] exp_prod(logic [15:0] a, logic [15:0] b, bit fr);
    logic signed [31:0] p;
    logic [39:0] e;
    p = $signed(a) * $signed(b);
    e = {{8{p[31]}}, p};
    return fr ? {e[38:0], 1'b0} : e;
  endfunction

  function automatic logic [15:0] exp_rnd(logic [39:0] acc, bit fr);
    return fr ? acc[31:16] + {15'd0, acc[15]} : acc[15:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_state(string req);
    logic [39:0] got;
    for (int k = 0; k < 5; k++) begin
      rd_sel = 3'(k);
      #0.2;
      got[8*k +: 8] = rd_byte;
    end
    rd_sel = 3'd5;
    #0.2;
    chk({req, "/R9 sel5"}, 64'(rd_byte), 64'h0);
    rd_sel = 3'd0;
    chk({req, "/R9 acc"}, 64'(got), 64'(m_acc));
    chk({req, "/R5 ovf"}, 64'(ovf), 64'(m_ovf));
    chk({req, "/R7 neg"}, 64'(neg), 64'(m_acc[39]));
    chk({req, "/R7 zero"}, 64'(zero), 64'(m_acc == 40'd0));
    chk({req, "/R8 rnd"}, 64'(rnd), 64'(exp_rnd(m_acc, m_frac)));
  endtask

  task automatic write_reg(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_frac = d[0];
      default: ;
    endcase
  endtask

  task automatic do_op(bit mul, bit clr);
    logic [39:0] p, s;
    @(negedge clk);
    start = 1'b1; op_mul = mul; clear = clr;
    @(negedge clk);
    start = 1'b0; op_mul = 1'b0; clear = 1'b0;
    p = exp_prod(m_a, m_b, m_frac);
    if (clr) begin
      m_acc = '0; m_ovf = 1'b0;
    end else if (mul) begin
      m_acc = p;
    end else begin
      s = m_acc + p;
      if (m_acc[39] == p[39] && s[39] != m_acc[39]) m_ovf = 1'b1;
      m_acc = s;
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    m_acc = '0; m_ovf = 1'b0;
  endtask

  initial begin
    #(8.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #20 rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");
    do_op(1'b0, 1'b0);
    check_state("R1 reset operands zero");

    // R2 integer 3 * -5
    write_reg(2'd0, 16'd3);
    write_reg(2'd1, 16'hFFFB);
    do_op(1'b0, 1'b0);
    chk("R2 int acc", 64'(m_acc), 64'hFF_FFFF_FFF1);
    check_state("R2 int");

    // R10 writes do not touch acc
    write_reg(2'd0, 16'h1234);
    write_reg(2'd2, 16'h0001);
    check_state("R10 hold");

    // R3 fractional 0.5*0.5, multiply-only R4
    write_reg(2'd0, 16'h4000);
    write_reg(2'd1, 16'h4000);
    do_op(1'b1, 1'b0);
    chk("R3 frac acc", 64'(m_acc), 64'h00_2000_0000);
    chk("R8 frac rnd", 64'(rnd), 64'h2000);
    check_state("R4 mul-only");

    // R8 round up from bit 15
    write_reg(2'd0, 16'h0001);
    do_op(1'b1, 1'b0);
    chk("R8 round up", 64'(rnd), 64'h0001);
    write_reg(2'd0, 16'hFFFF);
    do_op(1'b1, 1'b0);
    chk("R8 neg round to zero", 64'(rnd), 64'h0000);
    chk("R7 neg flag", 64'(neg), 64'h1);
    check_state("R8 neg");

    // R6 clear wins over start
    do_op(1'b0, 1'b1);
    check_state("R6 clear+start");

    // R5 integer overflow after 512 adds of 2^30
    write_reg(2'd2, 16'h0000);
    write_reg(2'd0, 16'h8000);
    write_reg(2'd1, 16'h8000);
    for (int i = 0; i < 511; i++) do_op(1'b0, 1'b0);
    check_state("R5 before ovf");
    do_op(1'b0, 1'b0);
    chk("R5 ovf set", 64'(ovf), 64'h1);
    check_state("R5 after ovf");
    write_reg(2'd0, 16'd1);
    write_reg(2'd1, 16'd1);
    do_op(1'b0, 1'b0);
    do_op(1'b1, 1'b0);
    chk("R5 sticky", 64'(ovf), 64'h1);
    check_state("R4 keeps ovf");
    do_clear();
    check_state("R6 clear");

    // R5 fractional overflow after 256 adds of 2^31
    write_reg(2'd2, 16'h0001);
    write_reg(2'd0, 16'h8000);
    write_reg(2'd1, 16'h8000);
    for (int i = 0; i < 256; i++) do_op(1'b0, 1'b0);
    chk("R5 frac ovf", 64'(ovf), 64'h1);
    check_state("R5 frac");
    do_clear();

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 12);
      if (r < 3) write_reg(2'd0, 16'($urandom));
      else if (r < 6) write_reg(2'd1, 16'($urandom));
      else if (r == 6) write_reg(2'd2, 16'($urandom));
      else if (r == 7) do_op(1'b1, 1'b0);
      else if (r == 8 && ($urandom % 4) == 0) do_clear();
      else do_op(1'b0, 1'b0);
      check_state("R2/R3 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule